// File: doc/BRIEF.md
# Ramp Phase Fault Supervisor

This block watches every controlled ramp phase of a multi-rail power sequencer and decides when the rails must be shut down. A cycle counter runs while a phase is active. The counter restarts at the start of each phase and stops when the phase reports completion. The limit comes from one of two 2-bit selections: one applies to ramping up and the other to ramping down. If a phase is still running when its limit is reached, the block faults. Any monitored input flagged out of range also faults the block, and in that case the shutdown request goes up in the same cycle, without waiting for a clock edge.

Once faulted, the block behaves in one of two ways, chosen by a mode bit. In latch-off mode it stays faulted until a clear event arrives. Three clear events are accepted: a change of level on the enable input, a change of level on the tracking-enable input, or a one-cycle software clear pulse. A power-cycle reset also clears it. In autoretry mode it counts a wait interval chosen by a 3-bit field. During that wait the fault output stays low and the shutdown request stays high. After the wait, the block holds off until the power-low indication reports that every output has discharged. It then issues a single-cycle retry request and leaves the faulted state.

Timing unit: one tick is `TICK_CYC` clock cycles (default 4).

Top module: `fault_supervisor`

## Requirements
- R1: After reset, with no input out of range, fault_n is 1, force_shutdown is 0 and retry_go is 0.
- R2: With dir_down = 0, a phase that runs for (TO_BASE << pu_to_sel) ticks without phase_done sets fault_n to 0 at the edge that ends the last counted cycle. The encodings are pu_to_sel 00/01/10/11 = 25/50/100/200 ticks at TO_BASE = 25. The first counted cycle is the first one in which phase_active is high.
- R3: With dir_down = 1, the limit is taken from pd_to_sel instead, using the same encoding. The value of pu_to_sel has no effect.
- R4: phase_done stops the phase counter, and no timeout follows. A new rising edge of phase_active restarts the count from zero.
- R5: If any bit of in_oor is 1 while the block is not faulted, force_shutdown is 1 in that same cycle, and fault_n is 0 from the next edge.
- R6: While faulted (fault_n = 0), force_shutdown is 1.
- R7: With latch_mode = 1, the fault is held until a clear event is sampled. A clear event is a level change of enable, a level change of trk_en, or sw_clear = 1. fault_n returns to 1 one edge later. A clear event sampled while any in_oor bit is 1 is ignored.
- R8: With latch_mode = 0, fault_n stays 0 for the wait of (RETRY_BASE << retry_sel) ticks, where RETRY_BASE = 8 by default. If all_low is 1 after the wait, the next edge raises retry_go and returns fault_n to 1 in the same cycle.
- R9: After the autoretry wait ends, retry_go is withheld and fault_n stays 0 for as long as all_low is 0.
- R10: retry_go is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-cycle reset |
| phase_active | input | 1 | A ramp phase is in progress |
| phase_done | input | 1 | Current phase has completed |
| dir_down | input | 1 | 1 = power-down phase, 0 = power-up phase |
| in_oor | input | NUM_IN | Per-input out-of-range flags |
| pu_to_sel | input | 2 | Power-up timeout selection |
| pd_to_sel | input | 2 | Power-down timeout selection |
| latch_mode | input | 1 | 1 = latch-off, 0 = autoretry |
| retry_sel | input | 3 | Autoretry wait selection |
| enable | input | 1 | Enable level; any change is a clear event |
| trk_en | input | 1 | Tracking-enable level; any change is a clear event |
| sw_clear | input | 1 | Software clear pulse |
| all_low | input | 1 | All outputs are discharged below the power-low level |
| fault_n | output | 1 | Active-low fault |
| force_shutdown | output | 1 | Request to turn all gate drives off |
| retry_go | output | 1 | Single-cycle request for a new power-up |

## Verification
The fault state is kept in a small state register, and fault_n and force_shutdown are decoded directly from it. A wrong state therefore shows at the ports in the very next cycle. If the block stays stuck in the running state, a timeout or input fault never pulls fault_n low. If it is stuck in a faulted state, fault_n never rises after a clear or a retry. An off-by-one in the phase or wait counter moves the fault_n or retry_go edge by one cycle. The checks therefore compare the cycle just before and the cycle of each expected edge.

// File: rtl/fault_supervisor_pkg.sv
package fault_supervisor_pkg;

  typedef enum logic [1:0] {
    SUP_RUN     = 2'd0,
    SUP_LATCHED = 2'd1,
    SUP_WAIT    = 2'd2,
    SUP_READY   = 2'd3
  } sup_state_e;

  // Phase timeout in cycles: base ticks doubled per selection step.
  function automatic int unsigned timeout_cycles(input logic [1:0] sel,
                                                 input int unsigned tick,
                                                 input int unsigned base);
    return (tick * base) << sel;
  endfunction

  // Autoretry wait in cycles.
  function automatic int unsigned retry_cycles(input logic [2:0] sel,
                                               input int unsigned tick,
                                               input int unsigned base);
    return (tick * base) << sel;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fault_supervisor_limit_counter.sv
module fault_supervisor_limit_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur;

  // Restart makes the current cycle the first counted one.
  assign cur = restart ? '0 : cnt;
  assign hit = run && (cur == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cur + CW'(run);
  end
endmodule

// File: rtl/fault_supervisor_clear_detect.sv
module fault_supervisor_clear_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trk_en,
  input  logic sw_clear,
  output logic clear_evt
);
  logic en_q;
  logic trk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      trk_q <= 1'b0;
    end else begin
      en_q  <= enable;
      trk_q <= trk_en;
    end
  end

  assign clear_evt = (enable ^ en_q) | (trk_en ^ trk_q) | sw_clear;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int unsigned TICK_CYC   = 4,
  parameter int unsigned TO_BASE    = 25,
  parameter int unsigned RETRY_BASE = 8,
  parameter int unsigned NUM_IN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_active,
  input  logic              phase_done,
  input  logic              dir_down,
  input  logic [NUM_IN-1:0] in_oor,
  input  logic [1:0]        pu_to_sel,
  input  logic [1:0]        pd_to_sel,
  input  logic              latch_mode,
  input  logic [2:0]        retry_sel,
  input  logic              enable,
  input  logic              trk_en,
  input  logic              sw_clear,
  input  logic              all_low,
  output logic              fault_n,
  output logic              force_shutdown,
  output logic              retry_go
);
  import fault_supervisor_pkg::*;

  localparam int unsigned TO_MAX = timeout_cycles(2'b11, TICK_CYC, TO_BASE);
  localparam int unsigned RT_MAX = retry_cycles(3'b111, TICK_CYC, RETRY_BASE);
  localparam int unsigned CW     = $clog2(max_u(TO_MAX, RT_MAX) + 1);

  sup_state_e    state;
  logic          pa_q;
  logic          stopped;
  logic          phase_start;
  logic          in_run;
  logic          to_run;
  logic          to_hit;
  logic          rt_hit;
  logic          oor_any;
  logic          clear_evt;
  logic          clear_ok;
  logic          fault_evt;
  logic [CW-1:0] to_limit;
  logic [CW-1:0] rt_limit;

  // Named internal events
  assign oor_any     = |in_oor;
  assign in_run      = (state == SUP_RUN);
  assign phase_start = phase_active & ~pa_q;
  assign to_run      = in_run & phase_active & ~phase_done & (phase_start | ~stopped);
  assign to_limit    = CW'(timeout_cycles(dir_down ? pd_to_sel : pu_to_sel, TICK_CYC, TO_BASE));
  assign rt_limit    = CW'(retry_cycles(retry_sel, TICK_CYC, RETRY_BASE));
  assign fault_evt   = in_run & (oor_any | to_hit);
  assign clear_ok    = clear_evt & ~oor_any;

  // Phase bookkeeping: restart on rising phase_active, freeze on phase_done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= 1'b0;
      stopped <= 1'b0;
    end else begin
      pa_q <= phase_active;
      if (phase_start)                    stopped <= phase_done;
      else if (phase_active & phase_done) stopped <= 1'b1;
      else if (!phase_active)             stopped <= 1'b0;
    end
  end

  fault_supervisor_limit_counter #(.CW(CW)) u_phase_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(phase_start),
    .run    (to_run),
    .limit  (to_limit),
    .hit    (to_hit)
  );

  fault_supervisor_limit_counter #(.CW(CW)) u_retry_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(state != SUP_WAIT),
    .run    (state == SUP_WAIT),
    .limit  (rt_limit),
    .hit    (rt_hit)
  );

  fault_supervisor_clear_detect u_clear (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .trk_en   (trk_en),
    .sw_clear (sw_clear),
    .clear_evt(clear_evt)
  );

  // Fault state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SUP_RUN;
      retry_go <= 1'b0;
    end else begin
      retry_go <= 1'b0;
      unique case (state)
        SUP_RUN: begin
          if (fault_evt) state <= latch_mode ? SUP_LATCHED : SUP_WAIT;
        end
        SUP_LATCHED: begin
          if (clear_ok) state <= SUP_RUN;
        end
        SUP_WAIT: begin
          if (clear_ok)    state <= SUP_RUN;
          else if (rt_hit) state <= SUP_READY;
        end
        SUP_READY: begin
          if (all_low) begin
            state    <= SUP_RUN;
            retry_go <= 1'b1;
          end else if (clear_ok) begin
            state <= SUP_RUN;
          end
        end
        default: state <= SUP_RUN;
      endcase
    end
  end

  assign fault_n        = in_run;
  assign force_shutdown = ~in_run | oor_any;

  // Assertions
  p_timeout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> !fault_n);

  p_oor_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && oor_any) |=> !fault_n);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUP_LATCHED && !clear_evt) |=> !fault_n);

  p_retry_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |-> (fault_n && $past(!fault_n)));

  p_retry_needs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |-> $past(all_low));

  p_retry_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |=> !retry_go);

endmodule

// File: tb/fault_supervisor_tb_top.sv
module fault_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_active = 1'b0, phase_done = 1'b0, dir_down = 1'b0;
  logic [3:0] in_oor = '0;
  logic [1:0] pu_to_sel = 2'b00, pd_to_sel = 2'b00;
  logic       latch_mode = 1'b1;
  logic [2:0] retry_sel = 3'b000;
  logic       enable = 1'b0, trk_en = 1'b0, sw_clear = 1'b0, all_low = 1'b0;
  logic       fault_n, force_shutdown, retry_go;

  always #10 clk = ~clk;   // 50 MHz

  fault_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .phase_active(phase_active), .phase_done(phase_done),
    .dir_down(dir_down), .in_oor(in_oor), .pu_to_sel(pu_to_sel), .pd_to_sel(pd_to_sel),
    .latch_mode(latch_mode), .retry_sel(retry_sel), .enable(enable), .trk_en(trk_en),
    .sw_clear(sw_clear), .all_low(all_low), .fault_n(fault_n),
    .force_shutdown(force_shutdown), .retry_go(retry_go)
  );

  typedef struct {
    int unsigned cyc;
    logic        fn;
    logic        fs;
    logic        rg;
    string       req;
  } exp_t;

  exp_t        sb[$];
  exp_t        item;
  int unsigned cyc = 0;
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop and compare expectations due this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item = sb.pop_front();
      compared++;
      if (item.cyc != cyc || fault_n !== item.fn || force_shutdown !== item.fs ||
          retry_go !== item.rg) begin
        mismatched++;
        $display("FAIL %s cyc %0d: fault_n/force_shutdown/retry_go = %b%b%b expected %b%b%b",
                 item.req, cyc, fault_n, force_shutdown, retry_go, item.fn, item.fs, item.rg);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_at(input int off, input logic fn, input logic fs,
                           input logic rg, input string req);
    exp_t e;
    e.cyc = cyc + off; e.fn = fn; e.fs = fs; e.rg = rg; e.req = req;
    sb.push_back(e);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      report();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_at(0, 1, 0, 0, "R1 reset state");
    step(2);

    // R2: power-up timeout, sel 00 = 100 cycles
    phase_active = 1'b1;
    expect_at(99, 1, 0, 0, "R2 before limit");
    expect_at(100, 0, 1, 0, "R2 at limit");
    step(102);
    phase_active = 1'b0;
    expect_at(20, 0, 1, 0, "R6 R7 latched hold");
    step(25);
    sw_clear = 1'b1;
    expect_at(1, 1, 0, 0, "R7 sw_clear");
    step(1);
    sw_clear = 1'b0;
    step(3);

    // R4: phase_done stops, new phase restarts from zero
    phase_active = 1'b1;
    step(50);
    phase_done = 1'b1;
    expect_at(149, 1, 0, 0, "R4 stopped timer");
    step(150);
    phase_active = 1'b0;
    phase_done = 1'b0;
    step(2);
    phase_active = 1'b1;
    expect_at(99, 1, 0, 0, "R4 restart before limit");
    expect_at(100, 0, 1, 0, "R4 restart at limit");
    step(102);
    phase_active = 1'b0;
    step(2);
    enable = 1'b1;
    expect_at(1, 1, 0, 0, "R7 enable toggle");
    step(3);

    // R3: power-down uses pd_to_sel (01 = 200 cycles)
    dir_down = 1'b1;
    pd_to_sel = 2'b01;
    phase_active = 1'b1;
    expect_at(199, 1, 0, 0, "R3 before limit");
    expect_at(200, 0, 1, 0, "R3 at limit");
    step(202);
    phase_active = 1'b0;
    dir_down = 1'b0;
    trk_en = 1'b1;
    expect_at(1, 1, 0, 0, "R7 trk_en toggle");
    step(3);

    // R5: out-of-range input
    in_oor = 4'b0100;
    expect_at(0, 1, 1, 0, "R5 same-cycle shutdown");
    expect_at(1, 0, 1, 0, "R5 fault next edge");
    step(1);
    in_oor = 4'b0001;
    sw_clear = 1'b1;
    expect_at(1, 0, 1, 0, "R7 clear ignored during oor");
    step(1);
    in_oor = 4'b0000;
    sw_clear = 1'b0;
    expect_at(1, 0, 1, 0, "R6 R7 still latched");
    step(2);
    sw_clear = 1'b1;
    expect_at(1, 1, 0, 0, "R7 clear after oor");
    step(1);
    sw_clear = 1'b0;
    step(2);

    // R8/R9: autoretry, sel 000 = 32 cycles, all_low held back
    latch_mode = 1'b0;
    retry_sel = 3'b000;
    all_low = 1'b0;
    in_oor = 4'b1000;
    step(1);
    in_oor = 4'b0000;
    expect_at(0, 0, 1, 0, "R8 fault entered");
    expect_at(31, 0, 1, 0, "R8 wait");
    expect_at(32, 0, 1, 0, "R9 wait over, outputs not low");
    expect_at(45, 0, 1, 0, "R9 held off");
    step(50);
    all_low = 1'b1;
    expect_at(1, 1, 0, 1, "R8 retry_go after all_low");
    expect_at(2, 1, 0, 0, "R10 single pulse");
    step(4);

    // R8: sel 001 = 64 cycles, all_low already high
    retry_sel = 3'b001;
    in_oor = 4'b0010;
    step(1);
    in_oor = 4'b0000;
    expect_at(64, 0, 1, 0, "R8 last wait cycle");
    expect_at(65, 1, 0, 1, "R8 retry_go");
    expect_at(66, 1, 0, 0, "R10 single pulse");
    step(70);

    while (sb.size() > 0) step(1);
    done = 1'b1;
    report();
  end
endmodule